// File: doc/BRIEF.md
# Floating-Point Load Expander (single/double to 80-bit extended)

This block takes an IEEE single-precision word, or the two words of an IEEE double-precision value, as they arrive from memory and rewrites the number in the 80-bit working-register layout: a sign, a 15-bit exponent biased by 16383, an explicit integer bit and a 63-bit fraction, spread across three 32-bit words. It sorts the operand into zero, subnormal, normal, infinity, quiet NaN or signalling NaN, rebiases the exponent, makes the integer bit explicit, and quiets a signalling NaN unless the caller has enabled the trap for it, in which case it raises an invalid-operation flag.

A conversion begins when `start` is sampled high while the block is idle. The block has three states. ST_IDLE waits for `start`. From ST_IDLE, an accepted start moves to ST_NORM when the operand is subnormal (IDLE->NORM) and to ST_DONE for every other operand and for unsupported length codes (IDLE->DONE). ST_NORM moves the mantissa one place left and lowers the exponent by one on every cycle. It stays in ST_NORM (NORM->NORM) until the shift that brings the leading one into the integer bit, and then moves to ST_DONE (NORM->DONE). ST_DONE raises `done` for one cycle and always returns to ST_IDLE (DONE->IDLE). The result words are registered and stay unchanged until the next accepted start. The conversion is always exact, so the block has no rounding logic.

Top module: `fp_load_expand`

## Requirements
- R1: `len_code` 2'b00 selects single (uses `mem_w0` only) and 2'b01 selects double (`mem_w0` high word, `mem_w1` low word). Codes 2'b10 and 2'b11 complete one cycle after acceptance with `unsupported`=1, `invalid`=0 and all three output words zero.
- R2: Output layout: `ext_w0`[31] is the sign, `ext_w0`[30:15] are zero, and `ext_w0`[14:0] is the exponent. `ext_w1`[31] is the integer bit J. The fraction starts at `ext_w1`[30] (its MSB) and continues into `ext_w2`. A single fraction fills `ext_w1`[30:8]. A double fraction fills `ext_w1`[30:0] and `ext_w2`[31:11]. All fraction bits below these are zero.
- R3: For a normal input (exponent neither 0 nor all ones), the output exponent is the input exponent + 16383 − 127 (single) or + 16383 − 1023 (double). J is 1 and the fraction is copied unchanged. `done` rises one cycle after acceptance.
- R4: A zero input gives exponent 0, J=0 and a zero fraction, with the input sign kept.
- R5: Infinity (exponent all ones, fraction zero) gives exponent 0x7FFF, J=0 and a zero fraction, with the input sign kept.
- R6: A quiet NaN (exponent all ones, fraction MSB 1) gives exponent 0x7FFF, J=0 and the fraction copied unchanged. `invalid` is 0.
- R7: A signalling NaN (exponent all ones, fraction MSB 0, fraction nonzero) with `trap_en`=0 gives exponent 0x7FFF and J=0. The fraction is copied with its MSB (`ext_w1`[30]) forced to 1, and `invalid` is 0.
- R8: A signalling NaN with `trap_en`=1 raises `invalid` together with `done`. The fraction is copied unchanged with no quieting.
- R9: A subnormal input is normalised so that J=1. Its exponent is 16383−126 (single) or 16383−1022 (double), minus the number of one-place shifts, where the shift count is the count of leading zeros of the fraction plus one. `done` rises that shift count plus one cycles after acceptance.
- R10: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle. The output words hold their values after `done` until the next accepted start.
- R11: A `start` that arrives while `busy` is high is ignored and does not change the result in progress.
- R12: After reset, `busy`, `done`, `invalid`, `unsupported` and all three output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion; accepted only when the block is idle |
| len_code | input | 2 | Memory format: 00 single, 01 double, 10/11 unsupported |
| mem_w0 | input | 32 | Single word, or high word of a double |
| mem_w1 | input | 32 | Low word of a double (ignored for single) |
| trap_en | input | 1 | 1: a signalling NaN raises invalid instead of being quieted |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe: result words and flags are valid |
| invalid | output | 1 | Invalid-operation flag, valid with done |
| unsupported | output | 1 | Length code not converted, valid with done |
| ext_w0 | output | 32 | Extended word 0: sign and 15-bit exponent |
| ext_w1 | output | 32 | Extended word 1: J and fraction MSBs |
| ext_w2 | output | 32 | Extended word 2: fraction LSBs |

## Verification
The bench sweeps every single-precision exponent against several fraction patterns and walks a lone subnormal leading one through every fraction position of both formats. Each result and each latency is compared with a value computed arithmetically in the bench.

Each corner case targets a specific fault:
- The subnormal sweep catches a normaliser that stops one shift early or late. Such a design shows J=0 or an exponent off by one, and its `done` arrives at the wrong cycle.
- The all-ones and all-zero exponents at both signs catch a design that muddles the classes. Such a design would set J on an infinity, lose the sign of a zero, or rebias a NaN exponent instead of forcing 0x7FFF.
- Signalling NaNs are run with the trap both enabled and disabled. This exposes a design that quiets under the wrong enable or never raises `invalid`.
- A `start` pulsed during a long normalisation catches a design that restarts mid-conversion.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_DONE = 2'd2
    } fpx_state_e;

    typedef enum logic [2:0] {
        CL_ZERO   = 3'd0,
        CL_SUBN   = 3'd1,
        CL_NORMAL = 3'd2,
        CL_INF    = 3'd3,
        CL_QNAN   = 3'd4,
        CL_SNAN   = 3'd5
    } fpx_class_e;

endpackage

// File: rtl/fpx_unpack.sv
// Splits a single or double operand into sign, class, rebiased exponent
// and a left-aligned fraction sized for the extended mantissa.
module fpx_unpack
    import fpx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SGL_EXP_W = 8,
    parameter int DBL_EXP_W = 11,
    parameter int EXT_EXP_W = 15,
    parameter int MANT_W    = 64
) (
    input  logic                 is_double,
    input  logic [WORD_W-1:0]    word_hi,
    input  logic [WORD_W-1:0]    word_lo,
    output logic                 sign,
    output fpx_class_e           cls,
    output logic [EXT_EXP_W-1:0] exp_out,
    output logic [MANT_W-2:0]    frac_out
);
    localparam int FRAC_W     = MANT_W - 1;
    localparam int SGL_FRAC_W = WORD_W - 1 - SGL_EXP_W;
    localparam int DBL_HI_W   = WORD_W - 1 - DBL_EXP_W;
    localparam int DBL_FRAC_W = DBL_HI_W + WORD_W;
    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;
    localparam logic [EXT_EXP_W-1:0] SGL_ADJ  = EXT_EXP_W'(EXT_BIAS - SGL_BIAS);
    localparam logic [EXT_EXP_W-1:0] DBL_ADJ  = EXT_EXP_W'(EXT_BIAS - DBL_BIAS);
    localparam logic [EXT_EXP_W-1:0] SGL_SUBE = EXT_EXP_W'(EXT_BIAS - SGL_BIAS + 1);
    localparam logic [EXT_EXP_W-1:0] DBL_SUBE = EXT_EXP_W'(EXT_BIAS - DBL_BIAS + 1);
    localparam logic [EXT_EXP_W-1:0] EXT_MAX  = '1;

    logic [DBL_EXP_W-1:0] exp_raw;
    logic                 exp_max;
    logic                 exp_zero;
    logic                 frac_nz;

    always_comb begin
        sign = word_hi[WORD_W-1];
        if (is_double) begin
            exp_raw  = word_hi[WORD_W-2 -: DBL_EXP_W];
            exp_max  = &word_hi[WORD_W-2 -: DBL_EXP_W];
            frac_out = {word_hi[DBL_HI_W-1:0], word_lo,
                        {(FRAC_W - DBL_FRAC_W){1'b0}}};
        end else begin
            exp_raw  = {{(DBL_EXP_W - SGL_EXP_W){1'b0}},
                        word_hi[WORD_W-2 -: SGL_EXP_W]};
            exp_max  = &word_hi[WORD_W-2 -: SGL_EXP_W];
            frac_out = {word_hi[SGL_FRAC_W-1:0],
                        {(FRAC_W - SGL_FRAC_W){1'b0}}};
        end
        exp_zero = (exp_raw == '0);
        frac_nz  = |frac_out;

        if (exp_max) begin
            exp_out = EXT_MAX;
            if (!frac_nz)                 cls = CL_INF;
            else if (frac_out[FRAC_W-1])  cls = CL_QNAN;
            else                          cls = CL_SNAN;
        end else if (exp_zero) begin
            if (frac_nz) begin
                cls     = CL_SUBN;
                exp_out = is_double ? DBL_SUBE : SGL_SUBE;
            end else begin
                cls     = CL_ZERO;
                exp_out = '0;
            end
        end else begin
            cls     = CL_NORMAL;
            exp_out = EXT_EXP_W'(exp_raw) + (is_double ? DBL_ADJ : SGL_ADJ);
        end
    end

endmodule

// File: rtl/fpx_pack.sv
// Lays sign, exponent and mantissa out as three extended-format words.
module fpx_pack #(
    parameter int WORD_W    = 32,
    parameter int EXT_EXP_W = 15,
    parameter int MANT_W    = 64
) (
    input  logic                 sign,
    input  logic [EXT_EXP_W-1:0] exp_in,
    input  logic [MANT_W-1:0]    mant_in,
    output logic [WORD_W-1:0]    w0,
    output logic [WORD_W-1:0]    w1,
    output logic [WORD_W-1:0]    w2
);
    localparam int PAD_W = WORD_W - 1 - EXT_EXP_W;

    assign w0 = {sign, {PAD_W{1'b0}}, exp_in};
    assign w1 = mant_in[MANT_W-1 -: WORD_W];
    assign w2 = mant_in[MANT_W-WORD_W-1 -: WORD_W];

endmodule

// File: rtl/fp_load_expand.sv
// Converts single or double memory operands into the 80-bit extended
// layout; subnormals are normalised one bit per cycle.
module fp_load_expand
    import fpx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SGL_EXP_W = 8,
    parameter int DBL_EXP_W = 11,
    parameter int EXT_EXP_W = 15,
    parameter int MANT_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        len_code,
    input  logic [WORD_W-1:0] mem_w0,
    input  logic [WORD_W-1:0] mem_w1,
    input  logic              trap_en,
    output logic              busy,
    output logic              done,
    output logic              invalid,
    output logic              unsupported,
    output logic [WORD_W-1:0] ext_w0,
    output logic [WORD_W-1:0] ext_w1,
    output logic [WORD_W-1:0] ext_w2
);
    localparam logic [MANT_W-2:0] QUIET_BIT = {1'b1, {(MANT_W-2){1'b0}}};

    fpx_state_e           state_q, state_d;
    logic                 sign_q;
    logic [EXT_EXP_W-1:0] exp_q;
    logic [MANT_W-1:0]    mant_q;
    logic                 inv_q;
    logic                 unsup_q;

    logic                 accept;
    logic                 fmt_ok;
    logic                 u_sign;
    fpx_class_e           u_cls;
    logic [EXT_EXP_W-1:0] u_exp;
    logic [MANT_W-2:0]    u_frac;

    assign accept = (state_q == ST_IDLE) && start;
    assign fmt_ok = !len_code[1];

    fpx_unpack #(
        .WORD_W    (WORD_W),
        .SGL_EXP_W (SGL_EXP_W),
        .DBL_EXP_W (DBL_EXP_W),
        .EXT_EXP_W (EXT_EXP_W),
        .MANT_W    (MANT_W)
    ) u_unpack (
        .is_double (len_code[0]),
        .word_hi   (mem_w0),
        .word_lo   (mem_w1),
        .sign      (u_sign),
        .cls       (u_cls),
        .exp_out   (u_exp),
        .frac_out  (u_frac)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (fmt_ok && (u_cls == CL_SUBN)) state_d = ST_NORM;
                    else                              state_d = ST_DONE;
                end
            end
            ST_NORM: begin
                if (mant_q[MANT_W-2]) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand registers and normalising shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q  <= 1'b0;
            exp_q   <= '0;
            mant_q  <= '0;
            inv_q   <= 1'b0;
            unsup_q <= 1'b0;
        end else if (accept) begin
            inv_q   <= 1'b0;
            unsup_q <= !fmt_ok;
            if (!fmt_ok) begin
                sign_q <= 1'b0;
                exp_q  <= '0;
                mant_q <= '0;
            end else begin
                sign_q <= u_sign;
                exp_q  <= u_exp;
                unique case (u_cls)
                    CL_ZERO:   mant_q <= '0;
                    CL_INF:    mant_q <= '0;
                    CL_NORMAL: mant_q <= {1'b1, u_frac};
                    CL_SUBN:   mant_q <= {1'b0, u_frac};
                    CL_QNAN:   mant_q <= {1'b0, u_frac};
                    CL_SNAN: begin
                        if (trap_en) begin
                            inv_q  <= 1'b1;
                            mant_q <= {1'b0, u_frac};
                        end else begin
                            mant_q <= {1'b0, u_frac | QUIET_BIT};
                        end
                    end
                    default:   mant_q <= '0;
                endcase
            end
        end else if (state_q == ST_NORM) begin
            mant_q <= mant_q << 1;
            exp_q  <= exp_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        invalid     = done && inv_q;
        unsupported = done && unsup_q;
    end

    fpx_pack #(
        .WORD_W    (WORD_W),
        .EXT_EXP_W (EXT_EXP_W),
        .MANT_W    (MANT_W)
    ) u_pack (
        .sign    (sign_q),
        .exp_in  (exp_q),
        .mant_in (mant_q),
        .w0      (ext_w0),
        .w1      (ext_w1),
        .w2      (ext_w2)
    );

endmodule

// File: rtl/fpx_chk.sv
module fpx_chk
    import fpx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int EXT_EXP_W = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 invalid,
    input logic                 unsupported,
    input logic [WORD_W-1:0]    ext_w0,
    input logic [WORD_W-1:0]    ext_w1,
    input logic [WORD_W-1:0]    ext_w2,
    input fpx_state_e           state_q,
    input logic [EXT_EXP_W-1:0] exp_q
);
    localparam logic [EXT_EXP_W-1:0] EMAX = '1;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ext_w0[WORD_W-2:EXT_EXP_W] == '0));

    // R3
    normal_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !unsupported && ext_w0[EXT_EXP_W-1:0] != '0
              && ext_w0[EXT_EXP_W-1:0] != EMAX) |-> ext_w1[WORD_W-1]);

    // R8
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (done && ext_w0[EXT_EXP_W-1:0] == EMAX
                     && !ext_w1[WORD_W-2]));

    // R1
    unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (done && !invalid && ext_w0 == '0
                         && ext_w1 == '0 && ext_w2 == '0));

    // R9
    norm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM) |=> (exp_q == $past(exp_q) - 1'b1));

    // R4
    zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ext_w0[EXT_EXP_W-1:0] == '0) |-> (ext_w1 == '0 && ext_w2 == '0));

endmodule

bind fp_load_expand fpx_chk #(
    .WORD_W    (WORD_W),
    .EXT_EXP_W (EXT_EXP_W)
) u_fpx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .invalid     (invalid),
    .unsupported (unsupported),
    .ext_w0      (ext_w0),
    .ext_w1      (ext_w1),
    .ext_w2      (ext_w2),
    .state_q     (state_q),
    .exp_q       (exp_q)
);

// File: tb/tb_fp_load_expand.sv
`timescale 1ns/1ps
module tb_fp_load_expand;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  len_code = 2'b00;
    logic [31:0] mem_w0 = '0;
    logic [31:0] mem_w1 = '0;
    logic        trap_en = 1'b0;
    logic        busy, done, invalid, unsupported;
    logic [31:0] ext_w0, ext_w1, ext_w2;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fp_load_expand dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len_code(len_code),
        .mem_w0(mem_w0), .mem_w1(mem_w1), .trap_en(trap_en),
        .busy(busy), .done(done), .invalid(invalid), .unsupported(unsupported),
        .ext_w0(ext_w0), .ext_w1(ext_w1), .ext_w2(ext_w2)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // reference conversion computed from the requirements
    task automatic model(input logic [1:0] len, input logic [31:0] a, input logic [31:0] b,
                         input logic trap, output logic [31:0] w0, output logic [31:0] w1,
                         output logic [31:0] w2, output logic inv, output logic uns,
                         output int lat, output string req);
        logic s;
        int e, emax, bias, xe;
        logic [51:0] f;
        logic [63:0] m;
        inv = 1'b0; uns = 1'b0; lat = 1;
        if (len[1]) begin
            w0 = '0; w1 = '0; w2 = '0; uns = 1'b1; req = "R1";
            return;
        end
        s = a[31];
        if (len == 2'b00) begin
            e = int'(a[30:23]); f = {a[22:0], 29'd0}; emax = 255; bias = 127;
        end else begin
            e = int'(a[30:20]); f = {a[19:0], b}; emax = 2047; bias = 1023;
        end
        if (e == emax) begin
            xe = 32767;
            if (f == 0) begin m = '0; req = "R5"; end
            else begin
                m = {1'b0, f, 11'd0};
                if (f[51]) req = "R6";
                else if (trap) begin inv = 1'b1; req = "R8"; end
                else begin m[62] = 1'b1; req = "R7"; end
            end
        end else if (e == 0) begin
            if (f == 0) begin xe = 0; m = '0; req = "R4"; end
            else begin
                xe = 16383 - (bias - 1);
                m = {1'b0, f, 11'd0};
                while (!m[63]) begin m = m << 1; xe--; lat++; end
                req = "R9";
            end
        end else begin
            xe = e + 16383 - bias;
            m = {1'b1, f, 11'd0};
            req = "R3";
        end
        w0 = {s, 16'd0, xe[14:0]};
        w1 = m[63:32];
        w2 = m[31:0];
    endtask

    task automatic run(input logic [1:0] len, input logic [31:0] a, input logic [31:0] b,
                       input logic trap);
        logic [31:0] x0, x1, x2;
        logic xi, xu;
        int xlat, n;
        string req;
        model(len, a, b, trap, x0, x1, x2, xi, xu, xlat, req);
        @(negedge clk);
        start = 1'b1; len_code = len; mem_w0 = a; mem_w1 = b; trap_en = trap;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin @(negedge clk); n++; end
        check({ext_w0, ext_w1, ext_w2, invalid, unsupported} == {x0, x1, x2, xi, xu},
              req, "result", {ext_w0, ext_w1, ext_w2, invalid, unsupported},
              {x0, x1, x2, xi, xu});
        check(n == xlat, req, "latency", 128'(n), 128'(xlat));
        @(negedge clk);
        // R10: strobe drops, words held
        check(!done && !busy && {ext_w0, ext_w1, ext_w2} == {x0, x1, x2}, "R10", "hold",
              {done, busy, ext_w0, ext_w1, ext_w2}, {2'b00, x0, x1, x2});
    endtask

    initial begin
        logic [22:0] sfr [5];
        sfr[0] = 23'h000000; sfr[1] = 23'h400000; sfr[2] = 23'h000001;
        sfr[3] = 23'h2AAAAA; sfr[4] = 23'h155555;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy && !done && !invalid && !unsupported &&
              ext_w0 == 0 && ext_w1 == 0 && ext_w2 == 0, "R12", "reset",
              {busy, done, invalid, unsupported, ext_w0, ext_w1, ext_w2}, '0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7 R8 R9: every single exponent, several fractions
        for (int e = 0; e < 256; e++)
            for (int k = 0; k < 5; k++)
                run(2'b00, {e[0] ^ k[0], e[7:0], sfr[k]}, 32'hDEADBEEF, e[1]);

        // R9: lone leading one at every single fraction position
        for (int p = 0; p < 23; p++) begin
            run(2'b00, 32'h0000_0000 | (32'h1 << p), '0, 1'b0);
            run(2'b00, 32'h8000_0000 | (32'h1 << p) | (32'h1 << (p / 2)), '0, 1'b0);
        end

        // R9: lone leading one at every double fraction position
        for (int p = 0; p < 52; p++) begin
            logic [51:0] fr;
            fr = 52'h1 << p;
            run(2'b01, {1'b0, 11'd0, fr[51:32]}, fr[31:0], 1'b0);
        end
        run(2'b01, 32'h800F_FFFF, 32'hFFFF_FFFF, 1'b0);

        // R3 R4 R5 R6 R7 R8: double exponent corners
        for (int k = 0; k < 10; k++) begin
            int ee;
            ee = (k < 5) ? k : 2043 + k - 5;
            if (k == 3) ee = 1023;
            if (k == 4) ee = 1024;
            run(2'b01, {1'b0, ee[10:0], 20'h00000}, 32'h0000_0000, 1'b0);
            run(2'b01, {1'b1, ee[10:0], 20'h80000}, 32'h0000_0001, 1'b1);
            run(2'b01, {1'b0, ee[10:0], 20'h00000}, 32'h0000_0001, 1'b0);
            run(2'b01, {1'b1, ee[10:0], 20'h12345}, 32'h6789_ABCD, 1'b1);
        end

        // R1: unsupported codes
        run(2'b10, 32'h3F80_0000, 32'h1234_5678, 1'b0);
        run(2'b11, 32'h7F80_0001, 32'h1234_5678, 1'b1);

        // R11: start during a long normalisation is ignored
        begin
            logic [31:0] x0, x1, x2;
            logic xi, xu;
            int xlat;
            string req;
            model(2'b01, 32'h0, 32'h1, 1'b0, x0, x1, x2, xi, xu, xlat, req);
            @(negedge clk);
            start = 1'b1; len_code = 2'b01; mem_w0 = 32'h0; mem_w1 = 32'h1; trap_en = 1'b0;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            start = 1'b1; len_code = 2'b00; mem_w0 = 32'h3F80_0000;
            @(negedge clk);
            start = 1'b0;
            for (int n = 0; n < 200 && !done; n++) @(negedge clk);
            check({ext_w0, ext_w1, ext_w2} == {x0, x1, x2}, "R11", "ignored start",
                  {ext_w0, ext_w1, ext_w2}, {x0, x1, x2});
            @(negedge clk);
            check(!busy && !done, "R11", "no restart", {busy, done}, '0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule